// File: doc/BRIEF.md
# DMA Offset/Repeat Address Generator

This block produces the source and destination addresses for one DMA channel, one transfer at a time. A per-transfer step strobe advances both pointers. The destination always moves forward by the access size, so the data lands in consecutive locations. The source can stay put, move up or down by the access size, or jump by a programmable offset. The source can also be confined to a repeat block: after a programmed number of bytes it returns to the address at which the block started, flags a repeat-end event and, if enabled, raises a sticky interrupt request.

Offset addition and repeat mode used together give an XY conversion, which is a transpose of a 4x4 matrix. For longword elements the setup is an offset of 0x10 and a 16-byte repeat block. Each block then reads one column. Between blocks, software writes a new source start address (the old one plus one element), and the next block uses that value. The bus interface, arbitration and data movement sit outside this block.

Top module: `dma_xy_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `src_addr` and `dst_addr` are 0 and `rpt_end` and `irq` are 0.
- R2: A `load` pulse takes `init_src` as both the current source address and the block start, takes `init_dst` as the destination address, and reloads the repeat counter. All three are visible in the cycle after the edge.
- R3: On each `step`, `dst_addr` grows by the access size. `acc_size` 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.
- R4: On a `step` that does not end a repeat block, the source moves according to `src_mode`: 0 keeps it fixed, 1 adds the access size, 2 subtracts the access size, and 3 adds `offset`.
- R5: With `rpt_en` set, a block holds `rpt_bytes` divided by the access size transfers, with a count of 0 acting as 1. The step that completes the block returns `src_addr` to the block start and reloads the counter.
- R6: `rpt_end` is high for exactly the one cycle after each step that completes a repeat block, and it is never high otherwise.
- R7: `irq` is set by a completed block while `rpt_ie` is 1 and stays set until `irq_clr`. A set in the same cycle as `irq_clr` wins.
- R8: A `src_wr` pulse makes `src_wdata` the new block start and the current source address, and reloads the repeat counter. `load` has priority over `src_wr`, and both have priority over `step`.
- R9: With `rpt_en` clear, no block ever ends. The source follows its mode without any restore, and `rpt_end` and `irq` stay 0.
- R10: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture start addresses and reload the repeat counter |
| init_src | input | 32 | Initial source address |
| init_dst | input | 32 | Initial destination address |
| src_wr | input | 1 | Software write of a new source block start |
| src_wdata | input | 32 | New source block start |
| step | input | 1 | One transfer has completed |
| acc_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| src_mode | input | 2 | 0 fixed, 1 increment, 2 decrement, 3 offset addition |
| offset | input | 32 | Source offset value |
| rpt_en | input | 1 | Source repeat block enable |
| rpt_bytes | input | 16 | Repeat block size in bytes |
| rpt_ie | input | 1 | Repeat-end interrupt enable |
| irq_clr | input | 1 | Clear the interrupt request |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| rpt_end | output | 1 | One-cycle repeat-end event |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench runs a full 4x4 longword transpose and checks every source address against the element index the transpose expects. A design that forgot to restore the start address, or that used the old start address after a software write, would read the wrong column. It ends a block with `irq_clr` asserted in the same cycle, to catch a clear that wins over a set, and it steps both pointers across the 2^32 boundary, to catch a wrap that is truncated or saturated. It also sends a `step` together with `load` and together with `src_wr`, runs a repeat count of 0, and steps with repeat disabled. A design with the wrong priorities would advance the pointers on those pulses, and a design that ignored `rpt_en` would end blocks that should never end.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic [1:0] {
    SRC_FIX = 2'd0,
    SRC_INC = 2'd1,
    SRC_DEC = 2'd2,
    SRC_OFS = 2'd3
  } src_mode_e;

  // byte count of one access: 0 -> 1, 1 -> 2, else 4
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_shift(input logic [1:0] sz);
    case (sz)
      2'd0:    size_shift = 2'd0;
      2'd1:    size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/dma_ag_rpt_cnt.sv
module dma_ag_rpt_cnt
  import dma_ag_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          step,
  input  logic          rpt_en,
  input  logic [RW-1:0] rpt_bytes,
  input  logic [1:0]    acc_size,
  output logic          blk_done
);
  logic [RW-1:0] cnt_q, cnt_d, reload_val;
  logic          cnt_en, last;

  always_comb begin
    reload_val = rpt_bytes >> size_shift(acc_size);
    last       = (cnt_q <= RW'(1));
    blk_done   = step && rpt_en && !reload && last;
    cnt_en     = reload || (step && rpt_en);
    cnt_d      = cnt_q;
    if (reload || blk_done) cnt_d = reload_val;
    else if (step && rpt_en) cnt_d = cnt_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dma_ag_src.sv
module dma_ag_src
  import dma_ag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] init_addr,
  input  logic          wr,
  input  logic [AW-1:0] wr_addr,
  input  logic          step,
  input  logic          restore,
  input  logic [1:0]    mode,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] start_q, start_d, cur_q, cur_d, sz;
  logic          start_en, cur_en;

  always_comb begin
    sz       = AW'(size_bytes(acc_size));
    start_en = load || wr;
    start_d  = load ? init_addr : wr_addr;
    cur_en   = load || wr || step;
    cur_d    = cur_q;
    if (load)         cur_d = init_addr;
    else if (wr)      cur_d = wr_addr;
    else if (restore) cur_d = start_q;
    else begin
      case (src_mode_e'(mode))
        SRC_INC: cur_d = cur_q + sz;
        SRC_DEC: cur_d = cur_q - sz;
        SRC_OFS: cur_d = cur_q + offset;
        default: cur_d = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
    end else begin
      if (start_en) start_q <= start_d;
      if (cur_en)   cur_q   <= cur_d;
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/dma_ag_dst.sv
module dma_ag_dst
  import dma_ag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] init_addr,
  input  logic          step,
  input  logic [1:0]    acc_size,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] cur_q, cur_d;
  logic          cur_en;

  always_comb begin
    cur_en = load || step;
    cur_d  = load ? init_addr : cur_q + AW'(size_bytes(acc_size));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  assign addr = cur_q;
endmodule

// File: rtl/dma_xy_addr_gen.sv
module dma_xy_addr_gen #(
  parameter int AW = 32,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] init_src,
  input  logic [AW-1:0] init_dst,
  input  logic          src_wr,
  input  logic [AW-1:0] src_wdata,
  input  logic          step,
  input  logic [1:0]    acc_size,
  input  logic [1:0]    src_mode,
  input  logic [AW-1:0] offset,
  input  logic          rpt_en,
  input  logic [RW-1:0] rpt_bytes,
  input  logic          rpt_ie,
  input  logic          irq_clr,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          rpt_end,
  output logic          irq
);
  logic eff_step, src_step, blk_done, cnt_reload;
  logic rpt_end_q, irq_q, irq_d, irq_en;

  always_comb begin
    cnt_reload = load || src_wr;
    eff_step   = step && !load;
    src_step   = step && !load && !src_wr;
  end

  dma_ag_rpt_cnt #(.RW(RW)) i_cnt (
    .clk(clk), .rst_n(rst_n), .reload(cnt_reload), .step(step),
    .rpt_en(rpt_en), .rpt_bytes(rpt_bytes), .acc_size(acc_size),
    .blk_done(blk_done)
  );

  dma_ag_src #(.AW(AW)) i_src (
    .clk(clk), .rst_n(rst_n), .load(load), .init_addr(init_src),
    .wr(src_wr), .wr_addr(src_wdata), .step(src_step), .restore(blk_done),
    .mode(src_mode), .acc_size(acc_size), .offset(offset), .addr(src_addr)
  );

  dma_ag_dst #(.AW(AW)) i_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .init_addr(init_dst),
    .step(eff_step), .acc_size(acc_size), .addr(dst_addr)
  );

  always_comb begin
    irq_en = irq_clr || (blk_done && rpt_ie);
    irq_d  = blk_done && rpt_ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_end_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rpt_end_q <= blk_done;
      if (irq_en) irq_q <= irq_d;
    end
  end

  assign rpt_end = rpt_end_q;
  assign irq     = irq_q;
endmodule

// File: rtl/dma_xy_addr_gen_chk.sv
module dma_xy_addr_gen_chk #(
  parameter int AW = 32,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [AW-1:0] init_src,
  input logic [AW-1:0] init_dst,
  input logic          src_wr,
  input logic [AW-1:0] src_wdata,
  input logic          step,
  input logic [1:0]    acc_size,
  input logic [1:0]    src_mode,
  input logic          rpt_en,
  input logic          rpt_ie,
  input logic          irq_clr,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          rpt_end,
  input logic          irq
);
  logic [AW-1:0] sz;
  assign sz = (acc_size == 2'd0) ? AW'(1) : (acc_size == 2'd1) ? AW'(2) : AW'(4);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (src_addr == $past(init_src)) && (dst_addr == $past(init_dst)) && !rpt_end);

  p_dst_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> dst_addr == $past(dst_addr) + $past(sz));

  p_src_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !src_wr && !rpt_en && src_mode == 2'd0) |=> $stable(src_addr));

  p_end_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_end |-> $past(step && rpt_en && !load && !src_wr));

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_end && $past(rpt_ie)) |-> irq);

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wr && !load) |=> src_addr == $past(src_wdata));

  p_no_rpt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rpt_en |=> !rpt_end);
endmodule

bind dma_xy_addr_gen dma_xy_addr_gen_chk #(.AW(AW), .RW(RW)) i_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .init_src(init_src), .init_dst(init_dst),
  .src_wr(src_wr), .src_wdata(src_wdata), .step(step), .acc_size(acc_size),
  .src_mode(src_mode), .rpt_en(rpt_en), .rpt_ie(rpt_ie), .irq_clr(irq_clr),
  .src_addr(src_addr), .dst_addr(dst_addr), .rpt_end(rpt_end), .irq(irq)
);

// File: tb/test_dma_xy_addr_gen.sv
`timescale 1ns/1ps
module test_dma_xy_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load, src_wr, step, rpt_en, rpt_ie, irq_clr;
  logic [31:0] init_src, init_dst, src_wdata, offset;
  logic [1:0]  acc_size, src_mode;
  logic [15:0] rpt_bytes;
  logic [31:0] src_addr, dst_addr;
  logic        rpt_end, irq;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  always #2 clk = ~clk;

  dma_xy_addr_gen i_dma_xy_addr_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .init_src(init_src), .init_dst(init_dst),
    .src_wr(src_wr), .src_wdata(src_wdata), .step(step), .acc_size(acc_size),
    .src_mode(src_mode), .offset(offset), .rpt_en(rpt_en), .rpt_bytes(rpt_bytes),
    .rpt_ie(rpt_ie), .irq_clr(irq_clr), .src_addr(src_addr), .dst_addr(dst_addr),
    .rpt_end(rpt_end), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_src, m_start, m_dst;
  int          m_left;
  bit          m_end, m_irq;

  function automatic int bytes_of(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic int blk_len();
    int n = int'(rpt_bytes) / bytes_of(acc_size);
    return (n < 1) ? 1 : n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_start = 0; m_dst = 0; m_left = 0; m_end = 0; m_irq = 0;
    end else begin
      bit fin;
      fin = 0;
      if (load) begin
        m_src = init_src; m_start = init_src; m_dst = init_dst; m_left = blk_len();
      end else begin
        if (step) m_dst = m_dst + 32'(bytes_of(acc_size));
        if (src_wr) begin
          m_src = src_wdata; m_start = src_wdata; m_left = blk_len();
        end else if (step) begin
          if (rpt_en && m_left <= 1) begin
            fin = 1; m_src = m_start; m_left = blk_len();
          end else begin
            if (rpt_en) m_left = m_left - 1;
            case (src_mode)
              2'd1: m_src = m_src + 32'(bytes_of(acc_size));
              2'd2: m_src = m_src - 32'(bytes_of(acc_size));
              2'd3: m_src = m_src + offset;
              default: ;
            endcase
          end
        end
      end
      m_end = fin;
      if (fin && rpt_ie) m_irq = 1;
      else if (irq_clr)  m_irq = 0;
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(tag, "src_addr", src_addr, m_src);
    chk(tag, "dst_addr", dst_addr, m_dst);
    chk(tag, "rpt_end", 32'(rpt_end), 32'(m_end));
    chk(tag, "irq", 32'(irq), 32'(m_irq));
  end

  task automatic idle();
    load = 0; src_wr = 0; step = 0; irq_clr = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1; idle();
  endtask

  task automatic do_load(input logic [31:0] s, input logic [31:0] d);
    load = 1; init_src = s; init_dst = d; cyc();
  endtask

  task automatic do_step(input int n);
    for (int i = 0; i < n; i++) begin step = 1; cyc(); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    init_src = 0; init_dst = 0; src_wdata = 0; offset = 0;
    acc_size = 2; src_mode = 0; rpt_en = 0; rpt_bytes = 0; rpt_ie = 0;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    chk("R1", "reset src", src_addr, 0);
    chk("R1", "reset irq", 32'(irq), 0);
    rst_n = 1;
    repeat (2) cyc();
    chk("R1", "post-reset dst", dst_addr, 0);

    // XY transpose, longword
    tag = "R2";
    acc_size = 2; src_mode = 3; offset = 32'h10; rpt_en = 1; rpt_bytes = 16; rpt_ie = 1;
    do_load(32'h1000, 32'h2000);
    chk("R2", "load src", src_addr, 32'h1000);
    chk("R2", "load dst", dst_addr, 32'h2000);
    tag = "R5";
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        #1;
        chk("R5", "transpose src", src_addr, 32'h1000 + 32'(4*b + 16*k));
        chk("R3", "transpose dst", dst_addr, 32'h2000 + 32'(4*(4*b + k)));
        step = 1; cyc();
      end
      chk("R6", "rpt_end pulse", 32'(rpt_end), 1);
      chk("R5", "restored src", src_addr, 32'h1000 + 32'(4*b));
      chk("R7", "irq set", 32'(irq), 1);
      irq_clr = 1; cyc();
      chk("R6", "rpt_end single cycle", 32'(rpt_end), 0);
      chk("R7", "irq cleared", 32'(irq), 0);
      tag = "R8";
      src_wr = 1; src_wdata = 32'h1000 + 32'(4*(b+1)); cyc();
      tag = "R5";
    end

    // set beats clear
    tag = "R7";
    do_load(32'h0, 32'h0);
    do_step(3);
    step = 1; irq_clr = 1; cyc();
    chk("R7", "set wins over clear", 32'(irq), 1);
    irq_clr = 1; cyc();

    // modes without repeat, byte and word
    tag = "R4";
    rpt_en = 0; rpt_ie = 1;
    acc_size = 0; src_mode = 1; do_load(32'h100, 32'h300); do_step(5);
    chk("R4", "byte inc", src_addr, 32'h105);
    acc_size = 1; src_mode = 2; do_step(3);
    chk("R4", "word dec", src_addr, 32'h0FF);
    src_mode = 0; do_step(2);
    chk("R4", "fixed", src_addr, 32'h0FF);
    acc_size = 3; src_mode = 3; offset = 32'h24; do_step(2);
    chk("R3", "size 3 as long", dst_addr, 32'h300 + 5 + 6 + 4 + 8);
    tag = "R9";
    do_step(20);
    chk("R9", "no irq without repeat", 32'(irq), 0);

    // priority
    tag = "R8";
    step = 1; load = 1; init_src = 32'h40; init_dst = 32'h80; cyc();
    chk("R8", "load beats step dst", dst_addr, 32'h80);
    step = 1; src_wr = 1; src_wdata = 32'h55; cyc();
    chk("R8", "wr beats step src", src_addr, 32'h55);

    // wrap
    tag = "R10";
    acc_size = 2; src_mode = 1;
    do_load(32'hFFFF_FFF8, 32'hFFFF_FFFC); do_step(3);
    chk("R10", "src wrap", src_addr, 32'h4);
    chk("R10", "dst wrap", dst_addr, 32'h8);

    // zero repeat count acts as one, word size, decrementing
    tag = "R5";
    rpt_en = 1; rpt_bytes = 0; rpt_ie = 0; src_mode = 2; acc_size = 1;
    do_load(32'h500, 32'h0); do_step(1);
    chk("R5", "count 0 ends at once", 32'(rpt_end), 1);
    rpt_bytes = 6; do_load(32'h500, 32'h0); do_step(2);
    chk("R5", "mid block", src_addr, 32'h4FC);
    do_step(1);
    chk("R5", "block of three restored", src_addr, 32'h500);
    chk("R7", "no irq when disabled", 32'(irq), 0);
    cyc(); cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule